// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a 16-bit local CPU address into a 23-bit global address. Three windows in the local space are paged: a 16 KB program window, a 4 KB RAM window and a 1 KB EEPROM window. Each window is steered by its own 8-bit page register. The rest of the local space is unpaged and lands at fixed global locations. In one of these unpaged regions the location depends on a single control bit, which can move the region to an external range.

The page registers and the control bit sit at fixed local addresses. They are read and written through a small register bus that shares the local address. A write takes effect on the clock edge that ends it, so the next access already uses the new value. Translation is purely combinational from the local address and the current register contents. Alongside the global address, the block reports a memory class and an external-access flag.

Top module: `paged_xlat`

## Requirements
- R1: A local address in 0x8000–0xBFFF maps to global 0x40_0000 + program_page × 0x4000 + (local & 0x3FFF), with memory class 3 (program flash) and the external flag at 0.
- R2: A local address in 0xC000–0xFFFF maps to global 0x7F_0000 + local with class 3, whatever value the program page holds.
- R3: With the control bit at 0, a local address in 0x4000–0x7FFF maps to 0x7F_0000 + local with class 3 and the external flag at 0.
- R4: With the control bit at 1, a local address in 0x4000–0x7FFF maps to 0x10_0000 + 0x4_0000 + local (0x14_4000–0x14_7FFF) with class 3 and the external flag at 1.
- R5: A local address in 0x1000–0x1FFF maps to ram_page × 0x1000 + (local & 0xFFF) with class 1 (RAM).
- R6: A local address in 0x0800–0x0BFF maps to 0x10_0000 + eeprom_page × 0x400 + (local & 0x3FF) with class 2 (EEPROM).
- R7: A write strobe at local 0x0030 (program page), 0x0016 (RAM page) or 0x0015 (EEPROM page) stores the write data at the clock edge, and the next access reads it back and translates with it. A write strobe at any other address changes no register. bus_rdata shows the addressed register and is 0 at every other address.
- R8: Any other local address maps to 0x7F_0000 + local with class 0 (unpaged) and the external flag at 0.
- R9: An access to a register address raises reg_hit and is not translated: class 4 (page register), the external flag at 0, and a global address of 0x7F_0000 + local.
- R10: After reset, the program page reads 0xFE, the RAM page reads 0xFD, the EEPROM page reads 0xFE and the control bit reads 0.
- R11: The control bit is bit 0 at local 0x0013. Bits 7:1 of a write there are ignored and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| local_addr | input | 16 | Local CPU address; also the register-bus address |
| bus_we | input | 1 | Write strobe for the register at local_addr |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register, 0 elsewhere |
| reg_hit | output | 1 | local_addr selects a page or control register |
| global_addr | output | 23 | Translated global address |
| mem_class | output | 3 | 0 unpaged, 1 RAM, 2 EEPROM, 3 program flash, 4 page register |
| ext_access | output | 1 | Access goes to the external range |

## Verification
The bench builds the block with its default parameters: 8-bit page registers, a 16-bit local address and a 23-bit global address. With these values the page extremes 0x00 and 0xFF can be written. That puts the lowest and highest global address of every paged window within reach, and it includes the top of the 4 MB program range at 0x7F_FFFF. With 16-bit local addresses, the bench can also place probes on both edges of every window boundary. Among these are the addresses just outside the EEPROM and RAM windows, which must fall back to the unpaged mapping.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int LA_W = 16;
  localparam int GA_W = 23;
  localparam int PG_W = 8;

  typedef enum logic [2:0] {
    CLS_UNPAGED = 3'd0,
    CLS_RAM     = 3'd1,
    CLS_EEPROM  = 3'd2,
    CLS_PFLASH  = 3'd3,
    CLS_PAGEREG = 3'd4
  } mem_class_e;
endpackage

// File: rtl/xlat_regs.sv
module xlat_regs
  import xlat_pkg::*;
#(
  parameter int LW  = LA_W,
  parameter int PW  = PG_W,
  parameter int NPG = 3,
  // index 0 EEPROM page, 1 RAM page, 2 program page
  parameter logic [3*16-1:0] PAGE_ADDRS = {16'h0030, 16'h0016, 16'h0015},
  parameter logic [3*8-1:0]  PAGE_RSTS  = {8'hFE, 8'hFD, 8'hFE},
  parameter logic [LW-1:0]   CTL_ADDR   = 16'h0013
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] addr,
  input  logic          we,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] rdata,
  output logic          hit,
  output logic [PW-1:0] page_ep,
  output logic [PW-1:0] page_rp,
  output logic [PW-1:0] page_pp,
  output logic          ctl_bit
);

  logic [PW-1:0]  page_q [NPG];
  logic [NPG-1:0] sel;
  logic [NPG-1:0] wr_en;
  logic           ctl_sel;
  logic           ctl_en;
  logic           ctl_q;

  for (genvar g = 0; g < NPG; g++) begin : g_page
    localparam logic [LW-1:0] P_ADDR = PAGE_ADDRS[g*16 +: 16];
    localparam logic [PW-1:0] P_RST  = PAGE_RSTS[g*8 +: 8];

    always_comb begin
      sel[g]   = (addr == P_ADDR);
      wr_en[g] = we && sel[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        page_q[g] <= P_RST;
      else if (wr_en[g]) page_q[g] <= wdata;
    end
  end

  always_comb begin
    ctl_sel = (addr == CTL_ADDR);
    ctl_en  = we && ctl_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= 1'b0;
    else if (ctl_en) ctl_q <= wdata[0];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NPG; i++) begin
      if (sel[i]) rdata = page_q[i];
    end
    if (ctl_sel) rdata = {{(PW-1){1'b0}}, ctl_q};
    hit = (|sel) | ctl_sel;
  end

  assign page_ep = page_q[0];
  assign page_rp = page_q[1];
  assign page_pp = page_q[2];
  assign ctl_bit = ctl_q;

endmodule

// File: rtl/xlat_map.sv
module xlat_map
  import xlat_pkg::*;
#(
  parameter int LW = LA_W,
  parameter int GW = GA_W,
  parameter int PW = PG_W
) (
  input  logic [LW-1:0] addr,
  input  logic [PW-1:0] page_ep,
  input  logic [PW-1:0] page_rp,
  input  logic [PW-1:0] page_pp,
  input  logic          ctl_bit,
  input  logic          reg_hit,
  output logic [GW-1:0] gaddr,
  output mem_class_e    cls,
  output logic          ext
);

  localparam logic [GW-1:0] UNP_BASE  = GW'(23'h7F_0000);
  localparam logic [GW-1:0] EXT_BASE  = GW'(23'h14_0000);
  localparam logic [GW-1:0] EE_BASE   = GW'(23'h10_0000);
  localparam logic [GW-1:0] PROG_BASE = GW'(23'h40_0000);

  always_comb begin
    gaddr = UNP_BASE + GW'(addr);
    cls   = CLS_UNPAGED;
    ext   = 1'b0;
    if (reg_hit) begin
      cls = CLS_PAGEREG;
    end else if (addr[LW-1 -: 2] == 2'b11) begin
      cls = CLS_PFLASH;
    end else if (addr[LW-1 -: 2] == 2'b10) begin
      gaddr = PROG_BASE + GW'({page_pp, addr[13:0]});
      cls   = CLS_PFLASH;
    end else if (addr[LW-1 -: 2] == 2'b01) begin
      cls = CLS_PFLASH;
      if (ctl_bit) begin
        gaddr = EXT_BASE + GW'(addr);
        ext   = 1'b1;
      end
    end else if (addr[LW-1 -: 4] == 4'h1) begin
      gaddr = GW'({page_rp, addr[11:0]});
      cls   = CLS_RAM;
    end else if (addr[LW-1 -: 6] == 6'b000010) begin
      gaddr = EE_BASE + GW'({page_ep, addr[9:0]});
      cls   = CLS_EEPROM;
    end
  end

endmodule

// File: rtl/paged_xlat.sv
module paged_xlat
  import xlat_pkg::*;
#(
  parameter int LW = LA_W,
  parameter int GW = GA_W,
  parameter int PW = PG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] local_addr,
  input  logic          bus_we,
  input  logic [PW-1:0] bus_wdata,
  output logic [PW-1:0] bus_rdata,
  output logic          reg_hit,
  output logic [GW-1:0] global_addr,
  output logic [2:0]    mem_class,
  output logic          ext_access
);

  logic [1:0]    rst_sync_q;
  logic          rst_sync_n;
  logic [PW-1:0] pg_ep, pg_rp, pg_pp;
  logic          ctl;
  mem_class_e    cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  xlat_regs #(.LW(LW), .PW(PW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .addr    (local_addr),
    .we      (bus_we),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .hit     (reg_hit),
    .page_ep (pg_ep),
    .page_rp (pg_rp),
    .page_pp (pg_pp),
    .ctl_bit (ctl)
  );

  xlat_map #(.LW(LW), .GW(GW), .PW(PW)) u_map (
    .addr    (local_addr),
    .page_ep (pg_ep),
    .page_rp (pg_rp),
    .page_pp (pg_pp),
    .ctl_bit (ctl),
    .reg_hit (reg_hit),
    .gaddr   (global_addr),
    .cls     (cls),
    .ext     (ext_access)
  );

  assign mem_class = cls;

endmodule

// File: rtl/xlat_chk.sv
module xlat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] local_addr,
  input logic        bus_we,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic        reg_hit,
  input logic [22:0] global_addr,
  input logic [2:0]  mem_class,
  input logic        ext_access
);

  p_upper_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (local_addr[15:14] == 2'b11) |-> (global_addr[22:16] == 7'h7F && global_addr[15:0] == local_addr
                                      && mem_class == 3'd3));

  p_ext_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_access |-> (local_addr[15:14] == 2'b01 && mem_class == 3'd3));

  p_write_visible_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && local_addr == 16'h0030) ##1 (local_addr == 16'h0030) |-> (bus_rdata == $past(bus_wdata)));

  p_rdata_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_hit |-> (bus_rdata == 8'h00));

  p_reg_untranslated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_hit |-> (mem_class == 3'd4 && !ext_access));

  p_ctl_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (local_addr == 16'h0013) |-> (bus_rdata[7:1] == 7'd0));

endmodule

bind paged_xlat xlat_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .local_addr  (local_addr),
  .bus_we      (bus_we),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .reg_hit     (reg_hit),
  .global_addr (global_addr),
  .mem_class   (mem_class),
  .ext_access  (ext_access)
);

// File: tb/test_paged_xlat.sv
module test_paged_xlat;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] local_addr;
  logic        bus_we;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        reg_hit;
  logic [22:0] global_addr;
  logic [2:0]  mem_class;
  logic        ext_access;

  always #5 clk = ~clk;

  paged_xlat i_paged_xlat (
    .clk         (clk),
    .rst_n       (rst_n),
    .local_addr  (local_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .reg_hit     (reg_hit),
    .global_addr (global_addr),
    .mem_class   (mem_class),
    .ext_access  (ext_access)
  );

  typedef struct {
    logic [15:0] a;
    logic [22:0] g;
    logic [2:0]  c;
    logic        x;
    logic [7:0]  rd;
    logic        h;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // shadow of the register contents, kept from the requirements
  int m_pp, m_rp, m_ep, m_ctl;

  task automatic expect_for(input logic [15:0] a, input string req);
    item_t it;
    int ai;
    ai = int'(a);
    it.a = a; it.req = req; it.x = 1'b0; it.rd = 8'h00; it.h = 1'b0;
    it.g = 23'(32'h7F0000 + ai); it.c = 3'd0;
    if (a == 16'h0030 || a == 16'h0016 || a == 16'h0015 || a == 16'h0013) begin
      it.h = 1'b1; it.c = 3'd4;
      if (a == 16'h0030) it.rd = 8'(m_pp);
      if (a == 16'h0016) it.rd = 8'(m_rp);
      if (a == 16'h0015) it.rd = 8'(m_ep);
      if (a == 16'h0013) it.rd = 8'(m_ctl);
    end else if (ai >= 'hC000) begin
      it.c = 3'd3;
    end else if (ai >= 'h8000) begin
      it.c = 3'd3; it.g = 23'('h400000 + m_pp * 'h4000 + (ai % 'h4000));
    end else if (ai >= 'h4000) begin
      it.c = 3'd3;
      if (m_ctl == 1) begin it.g = 23'('h140000 + ai); it.x = 1'b1; end
    end else if (ai >= 'h1000 && ai < 'h2000) begin
      it.c = 3'd1; it.g = 23'(m_rp * 'h1000 + (ai % 'h1000));
    end else if (ai >= 'h0800 && ai < 'h0C00) begin
      it.c = 3'd2; it.g = 23'('h100000 + m_ep * 'h400 + (ai % 'h400));
    end
    q.push_back(it);
  endtask

  task automatic look(input logic [15:0] a, input string req);
    @(negedge clk);
    local_addr = a;
    bus_we     = 1'b0;
    expect_for(a, req);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    local_addr = a;
    bus_we     = 1'b1;
    bus_wdata  = d;
    if (a == 16'h0030) m_pp = int'(d);
    if (a == 16'h0016) m_rp = int'(d);
    if (a == 16'h0015) m_ep = int'(d);
    if (a == 16'h0013) m_ctl = int'(d[0]);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  // monitor: compares one expected item per cycle after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (global_addr !== it.g || mem_class !== it.c || ext_access !== it.x ||
            bus_rdata !== it.rd || reg_hit !== it.h) begin
          fails++;
          $display("FAIL %s addr=%h got g=%h c=%0d x=%b rd=%h h=%b exp g=%h c=%0d x=%b rd=%h h=%b",
                   it.req, it.a, global_addr, mem_class, ext_access, bus_rdata, reg_hit,
                   it.g, it.c, it.x, it.rd, it.h);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired checks=%0d", checks);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    m_pp = 'hFE; m_rp = 'hFD; m_ep = 'hFE; m_ctl = 0;
    rst_n = 1'b0; local_addr = 16'h0000; bus_we = 1'b0; bus_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset values, R9 register accesses untranslated
    look(16'h0030, "R10");
    look(16'h0016, "R10");
    look(16'h0015, "R10");
    look(16'h0013, "R10_R9");

    // default mapping with reset pages
    look(16'h8000, "R1");
    look(16'hBFFF, "R1");
    look(16'hC000, "R2");
    look(16'hFFFF, "R2");
    look(16'h4000, "R3");
    look(16'h7FFF, "R3");
    look(16'h1000, "R5");
    look(16'h1FFF, "R5");
    look(16'h0800, "R6");
    look(16'h0BFF, "R6");
    look(16'h0000, "R8");
    look(16'h07FF, "R8");
    look(16'h0C00, "R8");
    look(16'h2000, "R8");
    look(16'h0FFF, "R8");

    // program page extremes
    wr(16'h0030, 8'h00);
    look(16'h0030, "R7");
    look(16'h8000, "R1_R7");
    wr(16'h0030, 8'hFF);
    look(16'hBFFF, "R1");
    look(16'hC123, "R2");
    wr(16'h0030, 8'h3C);
    look(16'hA5A5, "R1");
    look(16'hEEEE, "R2");

    // control bit
    wr(16'h0013, 8'hFF);
    look(16'h0013, "R11");
    look(16'h4000, "R4");
    look(16'h7FFF, "R4");
    look(16'h5A5A, "R4");
    look(16'hC000, "R2");
    wr(16'h0013, 8'hFE);
    look(16'h0013, "R11");
    look(16'h4000, "R3");

    // RAM page
    wr(16'h0016, 8'h00);
    look(16'h1000, "R5");
    wr(16'h0016, 8'hFF);
    look(16'h1FFF, "R5");
    look(16'h0016, "R7");

    // EEPROM page
    wr(16'h0015, 8'h00);
    look(16'h0800, "R6");
    wr(16'h0015, 8'hFF);
    look(16'h0BFF, "R6");
    wr(16'h0015, 8'h81);
    look(16'h0A55, "R6");

    // writes elsewhere change nothing
    wr(16'h0031, 8'h11);
    wr(16'h0014, 8'h22);
    wr(16'h8000, 8'h33);
    look(16'h0030, "R7");
    look(16'h0016, "R7");
    look(16'h0015, "R7");
    look(16'h0031, "R7_R8");

    // sweep a few addresses in every region
    for (int k = 0; k < 16; k++) begin
      look(16'(k * 16'h1000 + 16'h0123), "R8_sweep");
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule